// File: doc/BRIEF.md
# Nibble-Bus Host Master

This block drives a small port-expander chip that sits on a shared 4-bit bidirectional bus. The host side owns one 8-bit control word and can read back one 4-bit status nibble. The control word carries the outgoing nibble, an enable for an external outbound tri-state buffer, a strobe, and one active-low select line for each expander. A user request names an expander, a port, a direction and, for writes, a data nibble. The master turns that request into a fixed series of whole control-word values.

Each value in the series is held for a programmable number of clock cycles, so slow expanders and long board traces can be accommodated without changing the sequence. For a read, the master releases the buffer and lets the expander drive the bus. It samples the status nibble at the end of that turnaround step, corrects the inverted top bit, and presents the result with a one-cycle completion pulse. A busy flag covers the whole transaction, and any request made while it is high is dropped.

Top module: `nbus_host_master`

## Requirements
- R1: After reset, including a reset that arrives in the middle of a transaction, `ctrl_out` holds the idle word 0xE0: strobe high, every select high, buffer disabled, nibble zero. `busy` and `rd_done` are low.
- R2: The control-word layout is fixed. Bits [3:0] carry the bus nibble, bit 4 enables the outbound buffer, and bit 5 is the strobe. Bit 6 is the active-low select of expander 0 and bit 7 is the active-low select of expander 1. The select of the expander that is not addressed stays 1 for the whole transaction.
- R3: The command nibble is the port code plus 4 for a write and the port code alone for a read. The first two steps of every transaction carry it, with buffer enable on and the target selected: the first step with the strobe high, the second with the strobe low.
- R4: A write continues with data+enable (strobe low), then data+strobe+enable, then a closing word with strobe, both selects and enable set (0xF0).
- R5: A read continues with a turnaround word in which only the non-addressed select is 1 (buffer off, strobe low, target selected). It then closes with strobe plus both selects and the buffer off (0xE0).
- R6: Every step lasts `hold_cfg`+1 clock cycles. `hold_cfg` is sampled when the request is accepted, and later changes have no effect on that transaction.
- R7: Read data is `status_nib` with bit 3 inverted, sampled in the last cycle of the turnaround step. `rd_data` holds it and `rd_done` pulses for exactly the first cycle of the closing step.
- R8: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the last cycle of the closing step, which is 5×(`hold_cfg`+1) cycles for a write and 4×(`hold_cfg`+1) cycles for a read. After that the idle word returns.
- R9: Requests made while `busy` is high are refused and leave the running sequence and the following idle state unchanged.
- R10: A write transaction never raises `rd_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = port write, 0 = port read |
| req_unit | input | 1 | Expander index (0 or 1) |
| req_port | input | 2 | Port code on the expander |
| req_wdata | input | 4 | Nibble to write |
| hold_cfg | input | 8 | Extra cycles per step (step length = value + 1) |
| status_nib | input | 4 | Returned bus nibble (upper status bits) |
| ctrl_out | output | 8 | Control word to the port |
| busy | output | 1 | Transaction in progress |
| rd_done | output | 1 | One-cycle pulse with valid read data |
| rd_data | output | 4 | Corrected read nibble |

## Verification
The control word is registered, so after the accepting edge the first step's word appears at once. Every later word is due exactly `hold_cfg`+1 cycles after the previous one. The bench therefore walks each step cycle by cycle and compares `ctrl_out` and `busy` on falling edges against values it derives itself from the step list. `rd_done` and `rd_data` are due one cycle after the last turnaround cycle, which is the first cycle of the closing step. They are checked there and must be low in every other cycle. The idle word and a low `busy` are checked on the first cycle after the closing step, and also right after an asynchronous reset.

// File: rtl/nbh_pkg.sv
package nbh_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CMD_STB = 3'd1,
        PH_CMD     = 3'd2,
        PH_XFER    = 3'd3,
        PH_LATCH   = 3'd4,
        PH_CLOSE   = 3'd5
    } phase_e;

    // Step order: both directions share the command steps; only writes
    // pass through the data-latch step.
    function automatic phase_e phase_after(input phase_e cur, input logic wr);
        phase_e nxt;
        case (cur)
            PH_CMD_STB: nxt = PH_CMD;
            PH_CMD:     nxt = PH_XFER;
            PH_XFER:    nxt = wr ? PH_LATCH : PH_CLOSE;
            PH_LATCH:   nxt = PH_CLOSE;
            default:    nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/nbh_step_timer.sv
module nbh_step_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restart,
    input  logic [HOLD_W-1:0] hold_in,
    output logic              expire
);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [HOLD_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.hold = hold_in;
            tmr_d.cnt  = hold_in;
        end else if (restart) begin
            tmr_d.cnt  = tmr_q.hold;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expire = (tmr_q.cnt == '0);

endmodule

// File: rtl/nbh_word_enc.sv
module nbh_word_enc
    import nbh_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int PORT_W  = 2,
    parameter int N_UNITS = 2,
    parameter int UNIT_W  = 1,
    parameter int CW_W    = NIB_W + 2 + N_UNITS
) (
    input  phase_e            phase,
    input  logic              wr,
    input  logic [UNIT_W-1:0] unit,
    input  logic [PORT_W-1:0] port,
    input  logic [NIB_W-1:0]  wdata,
    output logic [CW_W-1:0]   word
);

    localparam int EN_BIT  = NIB_W;
    localparam int STB_BIT = NIB_W + 1;
    localparam int SEL_LO  = NIB_W + 2;

    logic [NIB_W-1:0] cmd_nib;
    logic [NIB_W-1:0] nib;
    logic             buf_en;
    logic             strobe;
    logic             target_on;

    assign cmd_nib = NIB_W'({wr, port});

    always_comb begin
        nib       = '0;
        buf_en    = 1'b0;
        strobe    = 1'b1;
        target_on = 1'b0;
        case (phase)
            PH_CMD_STB: begin
                nib = cmd_nib; buf_en = 1'b1; strobe = 1'b1; target_on = 1'b1;
            end
            PH_CMD: begin
                nib = cmd_nib; buf_en = 1'b1; strobe = 1'b0; target_on = 1'b1;
            end
            PH_XFER: begin
                nib = wr ? wdata : '0; buf_en = wr; strobe = 1'b0; target_on = 1'b1;
            end
            PH_LATCH: begin
                nib = wdata; buf_en = 1'b1; strobe = 1'b1; target_on = 1'b1;
            end
            PH_CLOSE: begin
                nib = '0; buf_en = wr; strobe = 1'b1; target_on = 1'b0;
            end
            default: begin
                nib = '0; buf_en = 1'b0; strobe = 1'b1; target_on = 1'b0;
            end
        endcase
    end

    assign word[NIB_W-1:0] = nib;
    assign word[EN_BIT]    = buf_en;
    assign word[STB_BIT]   = strobe;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_sel
        assign word[SEL_LO + u] = !(target_on && (unit == UNIT_W'(u)));
    end

endmodule

// File: rtl/nbh_readback.sv
module nbh_readback #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [NIB_W-1:0] status_nib,
    output logic [NIB_W-1:0] rd_data,
    output logic             rd_done
);

    localparam logic [NIB_W-1:0] FIX_MASK = NIB_W'(1) << (NIB_W - 1);

    typedef struct packed {
        logic [NIB_W-1:0] data;
        logic             done;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d      = rb_q;
        rb_d.done = capture;
        if (capture) begin
            rb_d.data = status_nib ^ FIX_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign rd_data = rb_q.data;
    assign rd_done = rb_q.done;

endmodule

// File: rtl/nbus_host_master.sv
module nbus_host_master
    import nbh_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int PORT_W  = 2,
    parameter int N_UNITS = 2,
    parameter int HOLD_W  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic                                  req_write,
    input  logic [((N_UNITS > 1) ? $clog2(N_UNITS) : 1)-1:0] req_unit,
    input  logic [PORT_W-1:0]                     req_port,
    input  logic [NIB_W-1:0]                      req_wdata,
    input  logic [HOLD_W-1:0]                     hold_cfg,
    input  logic [NIB_W-1:0]                      status_nib,
    output logic [NIB_W+2+N_UNITS-1:0]            ctrl_out,
    output logic                                  busy,
    output logic                                  rd_done,
    output logic [NIB_W-1:0]                      rd_data
);

    localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
    localparam int CW_W   = NIB_W + 2 + N_UNITS;
    localparam logic [CW_W-1:0] IDLE_WORD =
        {{N_UNITS{1'b1}}, 1'b1, 1'b0, {NIB_W{1'b0}}};

    typedef struct packed {
        phase_e            phase;
        logic              wr;
        logic [UNIT_W-1:0] unit;
        logic [PORT_W-1:0] port;
        logic [NIB_W-1:0]  wdata;
        logic [CW_W-1:0]   word;
    } mst_t;

    mst_t mst_d, mst_q;

    logic            step_end;
    logic            accept;
    logic            advance;
    logic            capture;
    phase_e          step_next;
    logic [CW_W-1:0] word_next;

    assign accept    = req_valid && (mst_q.phase == PH_IDLE);
    assign advance   = (mst_q.phase != PH_IDLE) && step_end;
    assign step_next = phase_after(mst_q.phase, mst_q.wr);
    assign capture   = advance && (mst_q.phase == PH_XFER) && !mst_q.wr;

    always_comb begin
        mst_d = mst_q;
        if (accept) begin
            mst_d.phase = PH_CMD_STB;
            mst_d.wr    = req_write;
            mst_d.unit  = req_unit;
            mst_d.port  = req_port;
            mst_d.wdata = req_wdata;
        end else if (advance) begin
            mst_d.phase = step_next;
        end
        mst_d.word = word_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q       <= '0;
            mst_q.phase <= PH_IDLE;
            mst_q.word  <= IDLE_WORD;
        end else begin
            mst_q <= mst_d;
        end
    end

    // Word is decoded from the next state and registered with it, so the
    // pins never see decode glitches and carry no extra cycle of delay.
    nbh_word_enc #(
        .NIB_W   (NIB_W),
        .PORT_W  (PORT_W),
        .N_UNITS (N_UNITS),
        .UNIT_W  (UNIT_W),
        .CW_W    (CW_W)
    ) u_enc (
        .phase (mst_d.phase),
        .wr    (mst_d.wr),
        .unit  (mst_d.unit),
        .port  (mst_d.port),
        .wdata (mst_d.wdata),
        .word  (word_next)
    );

    nbh_step_timer #(
        .HOLD_W (HOLD_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .restart (advance && (step_next != PH_IDLE)),
        .hold_in (hold_cfg),
        .expire  (step_end)
    );

    nbh_readback #(
        .NIB_W (NIB_W)
    ) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .status_nib (status_nib),
        .rd_data    (rd_data),
        .rd_done    (rd_done)
    );

    assign ctrl_out = mst_q.word;
    assign busy     = (mst_q.phase != PH_IDLE);

endmodule

// File: rtl/nbh_checker.sv
module nbh_checker #(
    parameter int NIB_W   = 4,
    parameter int N_UNITS = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       rd_done,
    input logic [NIB_W+2+N_UNITS-1:0] ctrl_out
);

    localparam int CW_W    = NIB_W + 2 + N_UNITS;
    localparam int EN_BIT  = NIB_W;
    localparam int STB_BIT = NIB_W + 1;
    localparam logic [CW_W-1:0] IDLE_WORD =
        {{N_UNITS{1'b1}}, 1'b1, 1'b0, {NIB_W{1'b0}}};

    logic [N_UNITS-1:0] sels;
    assign sels = ctrl_out[CW_W-1 -: N_UNITS];

    // R1
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ctrl_out == IDLE_WORD);

    // R2
    strobe_fall_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_out[STB_BIT]) |-> $countones(sels) == N_UNITS - 1);

    // R3
    start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ctrl_out[STB_BIT] && ctrl_out[EN_BIT]
                        && $countones(sels) == N_UNITS - 1);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7
    done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> busy && ctrl_out[STB_BIT] && !ctrl_out[EN_BIT] && (&sels));

    // R5
    sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !$past(ctrl_out[EN_BIT]) && !$past(ctrl_out[STB_BIT]));

    // R8
    end_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(ctrl_out[STB_BIT]) && (&$past(sels)));

endmodule

bind nbus_host_master nbh_checker #(
    .NIB_W   (NIB_W),
    .N_UNITS (N_UNITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rd_done  (rd_done),
    .ctrl_out (ctrl_out)
);

// File: tb/sim_nbus_host_master.sv
module sim_nbus_host_master;

    localparam int CLK_PERIOD = 10;

    // Vector layout (hex nibbles): write | unit | port | wdata | hold(2) | status(2) | exp_rd | poke
    localparam logic [39:0] VECS [8] = '{
        40'h1_0_0_F_00_00_0_0,
        40'h0_0_1_0_00_3C_B_0,
        40'h1_1_3_5_02_00_0_0,
        40'h0_1_2_0_01_F0_7_1,
        40'h1_0_2_A_03_00_0_1,
        40'h0_0_3_0_00_80_0_0,
        40'h0_0_0_0_05_05_8_0,
        40'h1_1_1_0_01_00_0_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [0:0] req_unit = '0;
    logic [1:0] req_port = '0;
    logic [3:0] req_wdata = '0;
    logic [7:0] hold_cfg = '0;
    logic [3:0] status_nib = '0;
    logic [7:0] ctrl_out;
    logic       busy;
    logic       rd_done;
    logic [3:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbus_host_master u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_unit   (req_unit),
        .req_port   (req_port),
        .req_wdata  (req_wdata),
        .hold_cfg   (hold_cfg),
        .status_nib (status_nib),
        .ctrl_out   (ctrl_out),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Words derived from R2..R5; ph 4 is the closing step.
    function automatic logic [7:0] expw(bit w, bit u, logic [1:0] p, logic [3:0] d, int ph);
        logic [7:0] oth;
        logic [7:0] cmd;
        oth = u ? 8'h40 : 8'h80;
        cmd = {5'b0, w, p};
        case (ph)
            0:       return oth | 8'h30 | cmd;
            1:       return oth | 8'h10 | cmd;
            2:       return w ? (oth | 8'h10 | {4'h0, d}) : oth;
            3:       return oth | 8'h30 | {4'h0, d};
            default: return w ? 8'hF0 : 8'hE0;
        endcase
    endfunction

    task automatic run_vec(input logic [39:0] v);
        bit         w;
        bit         u;
        logic [1:0] p;
        logic [3:0] d;
        logic [7:0] h;
        logic [3:0] e;
        bit         k;
        int         nst;
        w = v[36]; u = v[32]; p = v[29:28]; d = v[27:24];
        h = v[23:16]; e = v[7:4]; k = v[0];
        nst = w ? 5 : 4;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_unit = u; req_port = p;
        req_wdata = d; hold_cfg = h; status_nib = v[15:12];
        @(negedge clk);
        hold_cfg = ~h;                         // R6: must not affect this run
        if (k) begin
            req_write = ~w; req_port = ~p; req_unit = ~u; req_wdata = ~d;   // R9 poke
        end else begin
            req_valid = 1'b0;
        end
        for (int st = 0; st < nst; st++) begin
            for (int c = 0; c <= int'(h); c++) begin
                int ph;
                string tag;
                ph = w ? st : ((st == 3) ? 4 : st);
                if (c > 0)          tag = "R6";
                else if (st < 2)    tag = "R3";
                else if (w)         tag = "R4";
                else                tag = "R5";
                if (k) tag = {tag, "/R9"};
                chk(tag, ctrl_out, expw(w, u, p, d, ph));
                chk("R8 busy", {7'b0, busy}, 8'h01);
                if (st == 0 && c == 0)
                    chk("R2 selects", {6'b0, ctrl_out[7:6]}, u ? 8'h01 : 8'h02);
                if (!w && ph == 4 && c == 0) begin
                    chk("R7 done", {7'b0, rd_done}, 8'h01);
                    chk("R7 data", {4'b0, rd_data}, {4'b0, e});
                end else if (w) begin
                    chk("R10 no done", {7'b0, rd_done}, 8'h00);
                end else begin
                    chk("R7 no done", {7'b0, rd_done}, 8'h00);
                end
                if (st == nst - 1 && c == int'(h)) req_valid = 1'b0;
                @(negedge clk);
            end
        end
        chk("R8 idle busy", {7'b0, busy}, 8'h00);
        chk("R1 idle word", ctrl_out, 8'hE0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", ctrl_out, 8'hE0);
        chk("R1 reset busy", {7'b0, busy}, 8'h00);
        chk("R1 reset done", {7'b0, rd_done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R1: reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_unit = 1'b0; req_port = 2'd1;
        req_wdata = 4'h6; hold_cfg = 8'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 start", ctrl_out, 8'hB5);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset word", ctrl_out, 8'hE0);
        chk("R1 mid reset busy", {7'b0, busy}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", ctrl_out, 8'hE0);

        // R7: read on expander 1 with status top bit clear, long hold
        run_vec(40'h0_1_3_0_04_60_E_0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule